// File: doc/BRIEF.md
# Pushbutton Gesture Decoder

This block watches a single user pushbutton and turns press patterns into one-cycle action requests. The button level is expected to be synchronized and debounced upstream, and a one-cycle millisecond tick supplies the time base. The decoder recognises four multi-press bursts: a single short press, three presses, five presses and ten presses. It also recognises a long hold, and a soft power-off or power-on hold whose durations are programmed in seconds.

Each gesture has its own enable or disable input. When it is recognised, the block emits a pulse that asks other logic to act: reset the board, erase the key store, toggle the boot device, load factory settings, interrupt the host, or sequence the power rails. The block itself does none of these things. It also keeps a boot-select bit, which the five-press burst toggles, and a powered state bit, which the soft power gestures switch.

Top module: `pb_gesture_decoder`

## Requirements
- R1: After reset `powered_o` is 1, `boot_sel_o` is 0, and every action pulse is 0.
- R2: A burst of exactly one short press with `en_hard_reset_i` set gives exactly one `hard_reset_o` pulse and no `pb_irq_o`. With `en_hard_reset_i` clear, the same burst gives exactly one `pb_irq_o` pulse instead. A press is short when it lasts at most HOLD_MS+1 cycles with a tick on every cycle.
- R3: A burst of exactly three short presses gives one `key_erase_o` pulse when `en_key_clear_i` is set. The pulse is both the erase request and its interrupt. When `en_key_clear_i` is clear, the burst gives no pulse at all.
- R4: A burst of exactly five short presses with `en_alt_boot_i` set gives one `alt_boot_reset_o` pulse and inverts `boot_sel_o`. With the enable clear, no pulse is given and `boot_sel_o` keeps its value.
- R5: A burst of exactly ten short presses gives one `factory_load_o` pulse unless `ten_press_off_i` is set. If it is set, the burst gives nothing.
- R6: A burst ends when the button has stayed released for GAP_MS ticks. Only then is it classified, and it gives at most one action pulse. Press counts other than 1, 3, 5 and 10 give no pulse. Two presses separated by at least GAP_MS released ticks form two bursts.
- R7: A press is long once it has lasted more than HOLD_MS ticks. With `en_hold_i` set, it gives exactly one `hold_irq_o` pulse while still held. A long press is never counted as a burst press, whatever the enables.
- R8: While powered with `en_soft_power_i` set, a press longer than (high nibble of `press_time_i`) × MS_PER_SEC ticks gives one `power_off_o` pulse. The pulse comes while the button is still held, and `powered_o` then drops to 0. That press gives no burst action.
- R9: While not powered, a press held for at least (low nibble of `press_time_i`) × MS_PER_SEC ticks gives one `power_on_o` pulse, and `powered_o` returns to 1. Shorter presses are ignored. No burst or hold action is produced while not powered, and the waking press adds no burst press.
- R10: While `wake_protect_i` and `vin_low_i` are both 1, no wake happens, however long the press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| en_hard_reset_i | input | 1 | Single press requests hard reset instead of interrupt |
| en_key_clear_i | input | 1 | Enable triple-press key erase |
| en_soft_power_i | input | 1 | Enable soft power-off hold |
| en_alt_boot_i | input | 1 | Enable five-press boot toggle |
| en_hold_i | input | 1 | Enable hold interrupt |
| ten_press_off_i | input | 1 | Disable ten-press factory load |
| wake_protect_i | input | 1 | Block soft wake while input voltage is low |
| vin_low_i | input | 1 | Input voltage below minimum |
| press_time_i | input | 8 | Low nibble: wake seconds; high nibble: sleep seconds |
| hard_reset_o | output | 1 | Hard reset request pulse |
| pb_irq_o | output | 1 | Pushbutton interrupt pulse |
| key_erase_o | output | 1 | Key erase request and interrupt pulse |
| alt_boot_reset_o | output | 1 | Boot toggle reset request pulse |
| boot_sel_o | output | 1 | Boot device select, 0 = primary |
| factory_load_o | output | 1 | Factory settings load request pulse |
| hold_irq_o | output | 1 | Hold interrupt pulse |
| power_off_o | output | 1 | Soft power-down request pulse |
| power_on_o | output | 1 | Soft power-up request pulse |
| powered_o | output | 1 | 1 while the board is considered on |

## Verification
The assertions check several properties on every cycle. At most one burst verdict pulse fires at a time. `boot_sel_o` moves only together with a boot-toggle pulse. No burst action appears while the board is down. The powered state follows each power pulse, and it cannot rise while the low-voltage wake guard is active. Only the bench scenarios can show that press counts, enables and press lengths map to the right action, with the right count of pulses. They also show that a burst is split at the gap boundary, that a long or waking press adds nothing to a burst, and where the hold threshold lies to the exact cycle.

// File: rtl/pb_gesture_pkg.sv
// Shared types for the pushbutton gesture decoder.
// Assumes burst counts saturate well above ten.
package pb_gesture_pkg;

    typedef enum logic [2:0] {
        BURST_NONE,
        BURST_ONE,
        BURST_THREE,
        BURST_FIVE,
        BURST_TEN
    } burst_kind_e;

    // Maps a finished burst's press count to its gesture kind.
    function automatic burst_kind_e classify_burst(input int unsigned n);
        case (n)
            1:       return BURST_ONE;
            3:       return BURST_THREE;
            5:       return BURST_FIVE;
            10:      return BURST_TEN;
            default: return BURST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pbg_level_timer.sv
// Registers the button level and counts ticks spent at the current level.
// The count restarts at every level change and saturates at its maximum.
module pbg_level_timer #(
    parameter int DUR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             btn,
    output logic             lvl,
    output logic [DUR_W-1:0] dur
);
    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    // Track level and its duration in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            dur <= '0;
        end else begin
            lvl <= btn;
            if (btn != lvl)
                dur <= '0;
            else if (tick && dur != DUR_MAX)
                dur <= dur + 1'b1;
        end
    end

    assert_restart_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (btn != lvl) |=> (dur == '0 && lvl == $past(btn)));

endmodule

// File: rtl/pbg_burst.sv
// Counts short presses into bursts, classifies a burst once the release gap
// expires, and flags long holds. Expects lvl/dur from pbg_level_timer and a
// swallow flag that marks a press consumed by a power transition.
module pbg_burst
    import pb_gesture_pkg::*;
#(
    parameter int DUR_W   = 14,
    parameter int HOLD_MS = 700,
    parameter int GAP_MS  = 700,
    parameter int CNT_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [DUR_W-1:0] dur,
    input  logic             powered,
    input  logic             swallow,
    input  logic             en_hard,
    input  logic             en_key,
    input  logic             en_alt,
    input  logic             en_hold,
    input  logic             ten_off,
    output logic             hard_p,
    output logic             pbirq_p,
    output logic             key_p,
    output logic             alt_p,
    output logic             boot_sel,
    output logic             factory_p,
    output logic             hold_p
);
    localparam int               CW       = $clog2(CNT_MAX + 1);
    localparam logic [DUR_W-1:0] HOLD_LIM = DUR_W'(HOLD_MS);
    localparam logic [DUR_W-1:0] GAP_LIM  = DUR_W'(GAP_MS);
    localparam logic [CW-1:0]    CNT_TOP  = CW'(CNT_MAX);

    logic          lvl_d;
    logic          is_long;
    logic [CW-1:0] cnt;
    logic          release_now, long_now, hold_hit, settle;
    burst_kind_e   kind;

    // Derive release, long-press, hold and burst-settle conditions.
    always_comb begin
        release_now = lvl_d && !lvl;
        long_now    = lvl && (dur > HOLD_LIM || swallow);
        hold_hit    = lvl && powered && !swallow && !is_long && dur > HOLD_LIM;
        settle      = !lvl && powered && cnt != '0 && dur >= GAP_LIM;
        kind        = classify_burst(int'(cnt));
    end

    // Mark the current press long once it passes the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d   <= 1'b0;
            is_long <= 1'b0;
        end else begin
            lvl_d <= lvl;
            if (long_now)
                is_long <= 1'b1;
            else if (lvl && !lvl_d)
                is_long <= 1'b0;
        end
    end

    // Count short presses of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !powered)
            cnt <= '0;
        else if (settle)
            cnt <= '0;
        else if (release_now && is_long)
            cnt <= '0;
        else if (release_now && cnt != CNT_TOP)
            cnt <= cnt + 1'b1;
    end

    // Issue one action pulse per settled burst and per hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_p    <= 1'b0;
            pbirq_p   <= 1'b0;
            key_p     <= 1'b0;
            alt_p     <= 1'b0;
            factory_p <= 1'b0;
            hold_p    <= 1'b0;
            boot_sel  <= 1'b0;
        end else begin
            hard_p    <= settle && kind == BURST_ONE && en_hard;
            pbirq_p   <= settle && kind == BURST_ONE && !en_hard;
            key_p     <= settle && kind == BURST_THREE && en_key;
            alt_p     <= settle && kind == BURST_FIVE && en_alt;
            factory_p <= settle && kind == BURST_TEN && !ten_off;
            hold_p    <= hold_hit && en_hold;
            if (settle && kind == BURST_FIVE && en_alt)
                boot_sel <= !boot_sel;
        end
    end

    assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hard_p, pbirq_p, key_p, alt_p, factory_p}));
    assert_boot_moves_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel != $past(boot_sel)) |-> alt_p);
    assert_quiet_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |-> !(hard_p || pbirq_p || key_p || alt_p || factory_p || hold_p));
    assert_hold_while_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_p |-> $past(lvl));

endmodule

// File: rtl/pbg_softpower.sv
// Soft power state: a long press while on powers down, a press of the wake
// time while off powers up. The press causing a transition is marked consumed
// until release so it cannot trigger a second transition.
module pbg_softpower #(
    parameter int DUR_W      = 14,
    parameter int MS_PER_SEC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [DUR_W-1:0] dur,
    input  logic             en_soft,
    input  logic             wake_protect,
    input  logic             vin_low,
    input  logic [3:0]       on_sec,
    input  logic [3:0]       off_sec,
    output logic             powered,
    output logic             consumed,
    output logic             off_p,
    output logic             on_p
);
    localparam logic [DUR_W-1:0] SEC_STEP = DUR_W'(MS_PER_SEC);

    logic [DUR_W-1:0] on_ms, off_ms;
    logic             off_hit, on_hit;

    // Scale programmed seconds to ticks and test the thresholds.
    always_comb begin
        on_ms   = DUR_W'(on_sec) * SEC_STEP;
        off_ms  = DUR_W'(off_sec) * SEC_STEP;
        off_hit = powered && en_soft && lvl && !consumed && dur > off_ms;
        on_hit  = !powered && lvl && !consumed && dur >= on_ms
                  && !(wake_protect && vin_low);
    end

    // Update power state and issue transition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            powered  <= 1'b1;
            consumed <= 1'b0;
            off_p    <= 1'b0;
            on_p     <= 1'b0;
        end else begin
            off_p <= off_hit;
            on_p  <= on_hit;
            if (off_hit || on_hit) begin
                powered  <= on_hit;
                consumed <= 1'b1;
            end else if (!lvl) begin
                consumed <= 1'b0;
            end
        end
    end

    assert_off_drops_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off_p |-> !powered);
    assert_on_raises_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        on_p |-> powered);
    assert_wake_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_protect && vin_low && !powered) |=> !powered);

endmodule

// File: rtl/pb_gesture_decoder.sv
// Top of the pushbutton gesture decoder. Assumes btn_i is synchronized and
// debounced and ms_tick_i is a one-cycle pulse. All outputs are registered.
module pb_gesture_decoder #(
    parameter int HOLD_MS    = 700,
    parameter int GAP_MS     = 700,
    parameter int MS_PER_SEC = 1000,
    parameter int CNT_MAX    = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick_i,
    input  logic       btn_i,
    input  logic       en_hard_reset_i,
    input  logic       en_key_clear_i,
    input  logic       en_soft_power_i,
    input  logic       en_alt_boot_i,
    input  logic       en_hold_i,
    input  logic       ten_press_off_i,
    input  logic       wake_protect_i,
    input  logic       vin_low_i,
    input  logic [7:0] press_time_i,
    output logic       hard_reset_o,
    output logic       pb_irq_o,
    output logic       key_erase_o,
    output logic       alt_boot_reset_o,
    output logic       boot_sel_o,
    output logic       factory_load_o,
    output logic       hold_irq_o,
    output logic       power_off_o,
    output logic       power_on_o,
    output logic       powered_o
);
    localparam int LIM   = 15 * MS_PER_SEC + 2;
    localparam int MAXL  = (LIM > HOLD_MS + 2) ? ((LIM > GAP_MS + 2) ? LIM : GAP_MS + 2)
                                                : ((HOLD_MS > GAP_MS) ? HOLD_MS + 2 : GAP_MS + 2);
    localparam int DUR_W = $clog2(MAXL);

    logic             lvl;
    logic [DUR_W-1:0] dur;
    logic             consumed;

    pbg_level_timer #(.DUR_W(DUR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick_i), .btn(btn_i),
        .lvl(lvl), .dur(dur)
    );

    pbg_softpower #(.DUR_W(DUR_W), .MS_PER_SEC(MS_PER_SEC)) u_power (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .dur(dur),
        .en_soft(en_soft_power_i), .wake_protect(wake_protect_i), .vin_low(vin_low_i),
        .on_sec(press_time_i[3:0]), .off_sec(press_time_i[7:4]),
        .powered(powered_o), .consumed(consumed),
        .off_p(power_off_o), .on_p(power_on_o)
    );

    pbg_burst #(.DUR_W(DUR_W), .HOLD_MS(HOLD_MS), .GAP_MS(GAP_MS), .CNT_MAX(CNT_MAX)) u_burst (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .dur(dur),
        .powered(powered_o), .swallow(consumed),
        .en_hard(en_hard_reset_i), .en_key(en_key_clear_i), .en_alt(en_alt_boot_i),
        .en_hold(en_hold_i), .ten_off(ten_press_off_i),
        .hard_p(hard_reset_o), .pbirq_p(pb_irq_o), .key_p(key_erase_o),
        .alt_p(alt_boot_reset_o), .boot_sel(boot_sel_o),
        .factory_p(factory_load_o), .hold_p(hold_irq_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (powered_o && !boot_sel_o && !hard_reset_o && !power_off_o));

endmodule

// File: tb/pb_gesture_decoder_test.sv
module pb_gesture_decoder_test;
    localparam int HOLD = 7;
    localparam int GAP  = 7;
    localparam int SEC  = 10;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, btn = 1'b0;
    logic e_hard = 0, e_key = 0, e_soft = 0, e_alt = 0, e_hold = 0, ten_off = 0;
    logic wprot = 0, vlow = 0;
    logic [7:0] ptime = 8'h21;
    logic hard, pbirq, key, alt, bsel, fact, hold, poff, pon, pwr;

    int n_hard, n_pb, n_key, n_alt, n_fact, n_hold, n_off, n_on;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pb_gesture_decoder #(.HOLD_MS(HOLD), .GAP_MS(GAP), .MS_PER_SEC(SEC)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick_i(tick), .btn_i(btn),
        .en_hard_reset_i(e_hard), .en_key_clear_i(e_key), .en_soft_power_i(e_soft),
        .en_alt_boot_i(e_alt), .en_hold_i(e_hold), .ten_press_off_i(ten_off),
        .wake_protect_i(wprot), .vin_low_i(vlow), .press_time_i(ptime),
        .hard_reset_o(hard), .pb_irq_o(pbirq), .key_erase_o(key),
        .alt_boot_reset_o(alt), .boot_sel_o(bsel), .factory_load_o(fact),
        .hold_irq_o(hold), .power_off_o(poff), .power_on_o(pon), .powered_o(pwr)
    );

    always @(negedge clk) begin
        if (hard)  n_hard++;
        if (pbirq) n_pb++;
        if (key)   n_key++;
        if (alt)   n_alt++;
        if (fact)  n_fact++;
        if (hold)  n_hold++;
        if (poff)  n_off++;
        if (pon)   n_on++;
    end

    task automatic clr();
        @(negedge clk);
        n_hard = 0; n_pb = 0; n_key = 0; n_alt = 0;
        n_fact = 0; n_hold = 0; n_off = 0; n_on = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) begin
            @(posedge clk); #1 btn = 1'b0;
        end
    endtask

    task automatic press(input int c);
        for (int i = 0; i < c; i++) begin
            @(posedge clk); #1 btn = 1'b1;
        end
        @(posedge clk); #1 btn = 1'b0;
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            press(3);
            idle(2);
        end
        idle(GAP + 8);
    endtask

    task automatic all_quiet(input string req);
        chk(req, n_hard + n_pb + n_key + n_alt + n_fact + n_hold + n_off + n_on, 0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bs;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clr();
        // R1 reset state
        chk("R1 powered", pwr, 1);
        chk("R1 boot_sel", bsel, 0);
        chk("R1 pulses", hard | pbirq | key | alt | fact | hold | poff | pon, 0);

        // R2 single press, both enable settings
        e_hard = 1; clr(); burst(1);
        chk("R2 hard", n_hard, 1); chk("R2 pb", n_pb, 0);
        e_hard = 0; clr(); burst(1);
        chk("R2 pb", n_pb, 1); chk("R2 hard", n_hard, 0);

        // R3 triple press
        e_key = 1; clr(); burst(3);
        chk("R3 key", n_key, 1); chk("R3 no single", n_pb + n_hard, 0);
        e_key = 0; clr(); burst(3);
        all_quiet("R3 disabled");

        // R4 five presses toggle boot select
        e_alt = 1; clr(); burst(5);
        chk("R4 alt", n_alt, 1); chk("R4 sel", bsel, 1);
        clr(); burst(5);
        chk("R4 sel back", bsel, 0);
        e_alt = 0; clr(); burst(5);
        all_quiet("R4 disabled"); chk("R4 sel kept", bsel, 0);

        // R5 ten presses
        clr(); burst(10);
        chk("R5 factory", n_fact, 1);
        ten_off = 1; clr(); burst(10);
        all_quiet("R5 disabled");
        ten_off = 0;

        // R6 gap splits bursts
        e_hard = 1; clr();
        press(3); idle(GAP + 4); press(3); idle(GAP + 8);
        chk("R6 split", n_hard, 2);

        // R6 sweep of burst lengths with all gestures enabled
        e_key = 1; e_alt = 1; bs = 0;
        for (int n = 1; n <= 12; n++) begin
            clr(); burst(n);
            chk("R6 sweep hard", n_hard, (n == 1) ? 1 : 0);
            chk("R6 sweep key", n_key, (n == 3) ? 1 : 0);
            chk("R6 sweep alt", n_alt, (n == 5) ? 1 : 0);
            chk("R6 sweep factory", n_fact, (n == 10) ? 1 : 0);
            if (n == 5) bs = 1 - bs;
            chk("R6 sweep sel", bsel, bs);
        end
        e_key = 0; e_alt = 0;

        // R7 hold threshold sweep
        e_hold = 1;
        for (int p = 1; p <= 12; p++) begin
            clr(); press(p); idle(GAP + 8);
            chk("R7 hold", n_hold, (p >= HOLD + 2) ? 1 : 0);
            chk("R7 short", n_hard, (p <= HOLD + 1) ? 1 : 0);
        end
        e_hold = 0; clr(); press(15); idle(GAP + 8);
        all_quiet("R7 long press without hold");

        // R8 soft power off (high nibble 2 -> 20 ticks)
        e_soft = 1; clr(); press(30); idle(GAP + 8);
        chk("R8 off", n_off, 1); chk("R8 powered", pwr, 0);
        chk("R8 no burst", n_hard + n_pb, 0);

        // R9 short press while down is ignored
        clr(); burst(1);
        all_quiet("R9 short while down"); chk("R9 still down", pwr, 0);

        // R10 wake guard
        wprot = 1; vlow = 1; clr(); press(15); idle(GAP + 8);
        chk("R10 no wake", n_on, 0); chk("R10 still down", pwr, 0);

        // R9 wake press (low nibble 1 -> 10 ticks)
        vlow = 0; clr(); press(15); idle(GAP + 8);
        chk("R9 on", n_on, 1); chk("R9 powered", pwr, 1);
        chk("R9 waking press not counted", n_hard + n_hold + n_off, 0);

        // R2 normal operation after wake
        clr(); burst(1);
        chk("R2 after wake", n_hard, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule